// File: doc/BRIEF.md
# Multi-Hart Run Control Tracker

This block holds the run-control state that a debug controller keeps for each of its harts. Software writes a control word that picks one hart by index and, optionally, turns on array selection. Array selection adds every hart whose bit is set in a separate mask register. The same control write can carry one-shot commands that act on every selected hart: halt, resume, set halt-on-reset, clear halt-on-reset and acknowledge reset. It can also carry a level hart-reset value.

For each hart the block keeps five registered bits:

- a halt request;
- a pending resume request;
- a resume acknowledge;
- a halt-on-reset request;
- a sticky have-reset flag.

It drives the halt, resume, reset and halt-on-reset lines to each hart. It reads back each hart's halted and running levels and a one-cycle reset-done pulse. From these it reports any/all summaries over the harts currently selected.

The index field is wider than the implemented index. Writing all ones to it reads back the highest implemented index, so software can find out how many index bits exist. An index at or above the hart count reports the nonexistent state.

Top module: `hart_run_ctrl`

## Requirements
- R1: After reset the index, array-select enable, mask, and every per-hart halt request, resume request, resume acknowledge, halt-on-reset, hart-reset and have-reset bit are 0.
- R2: Hart n is selected when the index equals n, or when the array-select enable is 1 and mask bit n is 1. With the enable at 0 the mask selects nothing. A command uses the index and enable carried by the same control write.
- R3: Only the low IDX_W bits of the written index are stored, and the upper field bits read 0. With the defaults, writing 8'hFF reads back 8'h07.
- R4: A halt command sets the halt request of each selected hart that is not halted, on the clock edge of the write. A halted hart's request is not set. A raised request drops on the edge after the hart reports halted.
- R5: A resume command raises the resume request of each selected halted hart and holds it until the hart reports running and not halted. It raises nothing for running harts. A write carrying both halt and resume performs no resume.
- R6: A resume command clears the resume acknowledge of each selected hart. The acknowledge is set on the edge where its hart reports running while its resume request is pending. A hart that was already running when the command arrived keeps its acknowledge at 0.
- R7: The set and clear halt-on-reset commands change the bit only for selected harts. The bit drives the hart's halt-on-reset line. A reset-done pulse on a non-halted hart whose bit is set raises that hart's halt request on the same edge.
- R8: A reset-done pulse sets the hart's have-reset flag. Only an acknowledge-reset command with the hart selected clears it. The flags of other harts are left unchanged.
- R9: Each control write stores its hart-reset value into every selected hart and leaves unselected harts unchanged. The stored bit drives the hart's reset line.
- R10: Each hart is reported in exactly one state. It is halted when its halted input is 1, running when its running input is 1 and halted is 0, and unavailable otherwise. A stored index at or above NUM_HARTS is nonexistent.
- R11: Each any_* output is 1 when at least one selected hart is in that condition. Each all_* output is 1 when at least one existing hart is selected and every selected hart is in that condition. any_nonexist follows an out-of-range index. all_nonexist is 1 only when no existing hart is selected.
- R12: The mask changes only on a mask write. A control write, including one that toggles the array-select enable, leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_index | input | FIELD_W | Hart index field |
| ctl_multi_en | input | 1 | Array-select enable |
| ctl_halt | input | 1 | Halt command |
| ctl_resume | input | 1 | Resume command |
| ctl_set_hor | input | 1 | Set halt-on-reset command |
| ctl_clr_hor | input | 1 | Clear halt-on-reset command |
| ctl_ack_reset | input | 1 | Acknowledge (clear) have-reset command |
| ctl_hart_reset | input | 1 | Hart-reset level for selected harts |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_HARTS | New mask value |
| hart_halted_i | input | NUM_HARTS | Halted level from each hart |
| hart_running_i | input | NUM_HARTS | Running level from each hart |
| hart_reset_done_i | input | NUM_HARTS | One-cycle reset-complete pulse from each hart |
| sel_index_o | output | FIELD_W | Index read-back |
| multi_en_o | output | 1 | Array-select enable read-back |
| mask_o | output | NUM_HARTS | Mask read-back |
| hart_halt_req_o | output | NUM_HARTS | Halt request to each hart |
| hart_resume_req_o | output | NUM_HARTS | Resume request to each hart |
| hart_hor_o | output | NUM_HARTS | Halt-on-reset request to each hart |
| hart_reset_o | output | NUM_HARTS | Reset line to each hart |
| any_halted_o | output | 1 | Some selected hart halted |
| all_halted_o | output | 1 | All selected harts halted |
| any_running_o | output | 1 | Some selected hart running |
| all_running_o | output | 1 | All selected harts running |
| any_unavail_o | output | 1 | Some selected hart unavailable |
| all_unavail_o | output | 1 | All selected harts unavailable |
| any_nonexist_o | output | 1 | Selected index is out of range |
| all_nonexist_o | output | 1 | Only a nonexistent hart is selected |
| any_resumeack_o | output | 1 | Some selected hart has its resume acknowledge set |
| all_resumeack_o | output | 1 | All selected harts have their resume acknowledge set |
| any_havereset_o | output | 1 | Some selected hart has its have-reset flag set |
| all_havereset_o | output | 1 | All selected harts have their have-reset flag set |

## Verification
The clocked properties check several rules on every cycle:

- a halt request drops once its hart is halted;
- a resume request only rises for a hart that was halted;
- an acknowledge only rises after the hart was running;
- have-reset and halt-on-reset stay set unless their clearing command selects the hart;
- the mask holds steady without a mask write;
- no all_* summary is ever true without its any_* partner.

Other behaviour shows only in the bench's scenarios:

- which harts a given index/mask/enable combination actually selects;
- the index width discovered by writing all ones;
- halt winning over resume in the same write;
- the halt request raised by a reset-done pulse when halt-on-reset is set;
- the four-way state reported for mixed hart inputs.

// File: rtl/rc_pkg.sv
package rc_pkg;

   // One-shot and level actions carried by a control write
   typedef struct packed {
      logic halt;
      logic resume;
      logic set_hor;
      logic clr_hor;
      logic ack_reset;
      logic hart_reset;
   } rc_cmd_t;

endpackage

// File: rtl/rc_hart_select.sv
module rc_hart_select #(
   parameter int NUM_HARTS = 4,
   parameter int IDX_W     = 3,
   parameter int FIELD_W   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic [FIELD_W-1:0]   ctl_index,
   input  logic                 ctl_multi_en,
   input  logic                 mask_we,
   input  logic [NUM_HARTS-1:0] mask_wdata,
   output logic [IDX_W-1:0]     index_q,
   output logic                 multi_q,
   output logic [NUM_HARTS-1:0] mask_q,
   output logic [NUM_HARTS-1:0] sel_act,
   output logic [NUM_HARTS-1:0] sel_q,
   output logic                 idx_oob
);

   localparam logic [IDX_W:0] HART_LIMIT = (IDX_W+1)'(NUM_HARTS);

   logic [IDX_W-1:0] wr_idx;
   logic             unused_idx_hi;

   assign wr_idx        = ctl_index[IDX_W-1:0];
   assign unused_idx_hi = ^ctl_index[FIELD_W-1:IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '0;
         multi_q <= 1'b0;
         mask_q  <= '0;
      end else begin
         if (ctl_we) begin
            index_q <= wr_idx;
            multi_q <= ctl_multi_en;
         end
         if (mask_we) begin
            mask_q <= mask_wdata;
         end
      end
   end

   // Per-hart decode: the write-time view uses the incoming fields, the
   // held view uses the stored fields.
   for (genvar n = 0; n < NUM_HARTS; n++) begin : g_sel
      assign sel_act[n] = (wr_idx  == IDX_W'(n)) | (ctl_multi_en & mask_q[n]);
      assign sel_q[n]   = (index_q == IDX_W'(n)) | (multi_q      & mask_q[n]);
   end

   assign idx_oob = ({1'b0, index_q} >= HART_LIMIT);

   AST_MASK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q)); // R12

endmodule

// File: rtl/rc_hart_slot.sv
module rc_hart_slot
   import rc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cmd_v,
   input  rc_cmd_t cmd,
   input  logic    halted_i,
   input  logic    running_i,
   input  logic    reset_done_i,
   output logic    halt_req_o,
   output logic    resume_req_o,
   output logic    hor_o,
   output logic    hart_reset_o,
   output logic    resume_ack_o,
   output logic    havereset_o
);

   logic halt_req_q, resume_req_q, resume_ack_q, hor_q, hreset_q, havereset_q;
   logic run_eff, do_resume;

   assign run_eff   = running_i & ~halted_i;
   assign do_resume = cmd_v & cmd.resume & ~cmd.halt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_req_q   <= 1'b0;
         resume_req_q <= 1'b0;
         resume_ack_q <= 1'b0;
         hor_q        <= 1'b0;
         hreset_q     <= 1'b0;
         havereset_q  <= 1'b0;
      end else begin
         if (halted_i) begin
            halt_req_q <= 1'b0;
         end else if ((cmd_v & cmd.halt) | (reset_done_i & hor_q)) begin
            halt_req_q <= 1'b1;
         end

         if (do_resume & halted_i) begin
            resume_req_q <= 1'b1;
         end else if (run_eff) begin
            resume_req_q <= 1'b0;
         end

         if (do_resume) begin
            resume_ack_q <= 1'b0;
         end else if (resume_req_q & run_eff) begin
            resume_ack_q <= 1'b1;
         end

         if (cmd_v & cmd.set_hor) begin
            hor_q <= 1'b1;
         end else if (cmd_v & cmd.clr_hor) begin
            hor_q <= 1'b0;
         end

         if (cmd_v) begin
            hreset_q <= cmd.hart_reset;
         end

         if (reset_done_i) begin
            havereset_q <= 1'b1;
         end else if (cmd_v & cmd.ack_reset) begin
            havereset_q <= 1'b0;
         end
      end
   end

   assign halt_req_o   = halt_req_q;
   assign resume_req_o = resume_req_q;
   assign resume_ack_o = resume_ack_q;
   assign hor_o        = hor_q;
   assign hart_reset_o = hreset_q;
   assign havereset_o  = havereset_q;

   AST_HALTED_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      halted_i |=> !halt_req_q); // R4
   AST_RESUME_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resume_req_q) |-> $past(halted_i)); // R5
   AST_ACK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resume_ack_q) |-> $past(running_i)); // R6
   AST_HOR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      hor_q && !(cmd_v && cmd.clr_hor) |=> hor_q); // R7
   AST_HAVERESET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      havereset_q && !(cmd_v && cmd.ack_reset) |=> havereset_q); // R8

endmodule

// File: rtl/rc_status_agg.sv
module rc_status_agg #(
   parameter int NUM_HARTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_HARTS-1:0] sel,
   input  logic                 idx_oob,
   input  logic [NUM_HARTS-1:0] halted,
   input  logic [NUM_HARTS-1:0] running,
   input  logic [NUM_HARTS-1:0] rack,
   input  logic [NUM_HARTS-1:0] hrst,
   output logic                 any_halted,
   output logic                 all_halted,
   output logic                 any_running,
   output logic                 all_running,
   output logic                 any_unavail,
   output logic                 all_unavail,
   output logic                 any_nonexist,
   output logic                 all_nonexist,
   output logic                 any_rack,
   output logic                 all_rack,
   output logic                 any_hrst,
   output logic                 all_hrst
);

   logic [NUM_HARTS-1:0] st_halt, st_run, st_unav;
   logic                 some_sel;

   assign st_halt  = halted;
   assign st_run   = running & ~halted;
   assign st_unav  = ~running & ~halted;
   assign some_sel = |sel;

   assign any_halted   = |(sel & st_halt);
   assign all_halted   = some_sel & (&(~sel | st_halt));
   assign any_running  = |(sel & st_run);
   assign all_running  = some_sel & (&(~sel | st_run));
   assign any_unavail  = |(sel & st_unav);
   assign all_unavail  = some_sel & (&(~sel | st_unav));
   assign any_rack     = |(sel & rack);
   assign all_rack     = some_sel & (&(~sel | rack));
   assign any_hrst     = |(sel & hrst);
   assign all_hrst     = some_sel & (&(~sel | hrst));
   assign any_nonexist = idx_oob;
   assign all_nonexist = idx_oob & ~some_sel;

   AST_ALL_NEEDS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (all_halted -> any_halted) && (all_running -> any_running) &&
      (all_unavail -> any_unavail) && (all_nonexist -> any_nonexist)); // R11
   AST_STATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({all_halted, all_running, all_unavail, all_nonexist}) <= 1); // R10

endmodule

// File: rtl/hart_run_ctrl.sv
module hart_run_ctrl
   import rc_pkg::*;
#(
   parameter int NUM_HARTS = 4,
   parameter int IDX_W     = 3,
   parameter int FIELD_W   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic [FIELD_W-1:0]   ctl_index,
   input  logic                 ctl_multi_en,
   input  logic                 ctl_halt,
   input  logic                 ctl_resume,
   input  logic                 ctl_set_hor,
   input  logic                 ctl_clr_hor,
   input  logic                 ctl_ack_reset,
   input  logic                 ctl_hart_reset,
   input  logic                 mask_we,
   input  logic [NUM_HARTS-1:0] mask_wdata,
   input  logic [NUM_HARTS-1:0] hart_halted_i,
   input  logic [NUM_HARTS-1:0] hart_running_i,
   input  logic [NUM_HARTS-1:0] hart_reset_done_i,
   output logic [FIELD_W-1:0]   sel_index_o,
   output logic                 multi_en_o,
   output logic [NUM_HARTS-1:0] mask_o,
   output logic [NUM_HARTS-1:0] hart_halt_req_o,
   output logic [NUM_HARTS-1:0] hart_resume_req_o,
   output logic [NUM_HARTS-1:0] hart_hor_o,
   output logic [NUM_HARTS-1:0] hart_reset_o,
   output logic                 any_halted_o,
   output logic                 all_halted_o,
   output logic                 any_running_o,
   output logic                 all_running_o,
   output logic                 any_unavail_o,
   output logic                 all_unavail_o,
   output logic                 any_nonexist_o,
   output logic                 all_nonexist_o,
   output logic                 any_resumeack_o,
   output logic                 all_resumeack_o,
   output logic                 any_havereset_o,
   output logic                 all_havereset_o
);

   if (NUM_HARTS < 1) begin : g_chk_harts
      $error("hart_run_ctrl: NUM_HARTS must be at least 1");
   end
   if ((1 << IDX_W) < NUM_HARTS) begin : g_chk_idx
      $error("hart_run_ctrl: IDX_W too narrow for NUM_HARTS");
   end
   if (FIELD_W <= IDX_W) begin : g_chk_field
      $error("hart_run_ctrl: FIELD_W must exceed IDX_W");
   end

   logic [IDX_W-1:0]     index_q;
   logic [NUM_HARTS-1:0] sel_act, sel_q, rack, hrst;
   logic                 idx_oob;
   rc_cmd_t              cmd;

   assign cmd = '{halt:       ctl_halt,
                  resume:     ctl_resume,
                  set_hor:    ctl_set_hor,
                  clr_hor:    ctl_clr_hor,
                  ack_reset:  ctl_ack_reset,
                  hart_reset: ctl_hart_reset};

   rc_hart_select #(
      .NUM_HARTS (NUM_HARTS),
      .IDX_W     (IDX_W),
      .FIELD_W   (FIELD_W)
   ) u_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_we       (ctl_we),
      .ctl_index    (ctl_index),
      .ctl_multi_en (ctl_multi_en),
      .mask_we      (mask_we),
      .mask_wdata   (mask_wdata),
      .index_q      (index_q),
      .multi_q      (multi_en_o),
      .mask_q       (mask_o),
      .sel_act      (sel_act),
      .sel_q        (sel_q),
      .idx_oob      (idx_oob)
   );

   assign sel_index_o = FIELD_W'(index_q);

   for (genvar n = 0; n < NUM_HARTS; n++) begin : g_slot
      rc_hart_slot u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .cmd_v        (ctl_we & sel_act[n]),
         .cmd          (cmd),
         .halted_i     (hart_halted_i[n]),
         .running_i    (hart_running_i[n]),
         .reset_done_i (hart_reset_done_i[n]),
         .halt_req_o   (hart_halt_req_o[n]),
         .resume_req_o (hart_resume_req_o[n]),
         .hor_o        (hart_hor_o[n]),
         .hart_reset_o (hart_reset_o[n]),
         .resume_ack_o (rack[n]),
         .havereset_o  (hrst[n])
      );
   end

   rc_status_agg #(
      .NUM_HARTS (NUM_HARTS)
   ) u_agg (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel          (sel_q),
      .idx_oob      (idx_oob),
      .halted       (hart_halted_i),
      .running      (hart_running_i),
      .rack         (rack),
      .hrst         (hrst),
      .any_halted   (any_halted_o),
      .all_halted   (all_halted_o),
      .any_running  (any_running_o),
      .all_running  (all_running_o),
      .any_unavail  (any_unavail_o),
      .all_unavail  (all_unavail_o),
      .any_nonexist (any_nonexist_o),
      .all_nonexist (all_nonexist_o),
      .any_rack     (any_resumeack_o),
      .all_rack     (all_resumeack_o),
      .any_hrst     (any_havereset_o),
      .all_hrst     (all_havereset_o)
   );

endmodule

// File: tb/tb_hart_run_ctrl.sv
module tb_hart_run_ctrl;

   localparam int NH = 4;

   // Action word: {halt, resume, set_hor, clr_hor, ack_reset, hart_reset}
   localparam logic [5:0] A_NONE = 6'b000000;
   localparam logic [5:0] A_HALT = 6'b100000;
   localparam logic [5:0] A_RES  = 6'b010000;
   localparam logic [5:0] A_SHOR = 6'b001000;
   localparam logic [5:0] A_CHOR = 6'b000100;
   localparam logic [5:0] A_ACK  = 6'b000010;
   localparam logic [5:0] A_HRST = 6'b000001;

   // Vector: idx[23:21] multi[20] mask[19:16] halted[15:12] running[11:8]
   // expected {anyH,allH,anyR,allR,anyU,allU,anyN,allN}[7:0]
   localparam int NVEC = 8;
   localparam logic [23:0] VEC [NVEC] = '{
      {3'd0, 1'b0, 4'b0000, 4'b0001, 4'b0000, 8'b1100_0000},
      {3'd1, 1'b0, 4'b1111, 4'b0001, 4'b0010, 8'b0011_0000},
      {3'd1, 1'b1, 4'b0101, 4'b0001, 4'b0010, 8'b1010_1000},
      {3'd5, 1'b0, 4'b0000, 4'b1111, 4'b0000, 8'b0000_0011},
      {3'd6, 1'b1, 4'b1100, 4'b1100, 4'b0000, 8'b1100_0010},
      {3'd3, 1'b1, 4'b1000, 4'b0000, 4'b1000, 8'b0011_0000},
      {3'd2, 1'b0, 4'b0000, 4'b0100, 4'b0100, 8'b1100_0000},
      {3'd0, 1'b1, 4'b1110, 4'b0000, 4'b0000, 8'b0000_1100}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_we = 1'b0;
   logic [7:0]    ctl_index = '0;
   logic          ctl_multi_en = 1'b0;
   logic [5:0]    act = '0;
   logic          mask_we = 1'b0;
   logic [NH-1:0] mask_wdata = '0;
   logic [NH-1:0] halted = '0, running = '0, rdone = '0;

   logic [7:0]    sel_index_o;
   logic          multi_en_o;
   logic [NH-1:0] mask_o, halt_req, resume_req, hor, hreset;
   logic any_h, all_h, any_r, all_r, any_u, all_u, any_n, all_n;
   logic any_ra, all_ra, any_hr, all_hr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hart_run_ctrl dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .ctl_we            (ctl_we),
      .ctl_index         (ctl_index),
      .ctl_multi_en      (ctl_multi_en),
      .ctl_halt          (act[5]),
      .ctl_resume        (act[4]),
      .ctl_set_hor       (act[3]),
      .ctl_clr_hor       (act[2]),
      .ctl_ack_reset     (act[1]),
      .ctl_hart_reset    (act[0]),
      .mask_we           (mask_we),
      .mask_wdata        (mask_wdata),
      .hart_halted_i     (halted),
      .hart_running_i    (running),
      .hart_reset_done_i (rdone),
      .sel_index_o       (sel_index_o),
      .multi_en_o        (multi_en_o),
      .mask_o            (mask_o),
      .hart_halt_req_o   (halt_req),
      .hart_resume_req_o (resume_req),
      .hart_hor_o        (hor),
      .hart_reset_o      (hreset),
      .any_halted_o      (any_h),
      .all_halted_o      (all_h),
      .any_running_o     (any_r),
      .all_running_o     (all_r),
      .any_unavail_o     (any_u),
      .all_unavail_o     (all_u),
      .any_nonexist_o    (any_n),
      .all_nonexist_o    (all_n),
      .any_resumeack_o   (any_ra),
      .all_resumeack_o   (all_ra),
      .any_havereset_o   (any_hr),
      .all_havereset_o   (all_hr)
   );

   task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
      checks++;
      if (actual !== expected) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
      end
   endtask

   // Control write: fields valid across one rising edge, sampled at next falling edge
   task automatic ctl(input logic [7:0] idx, input logic multi, input logic [5:0] a);
      @(negedge clk);
      ctl_we = 1'b1; ctl_index = idx; ctl_multi_en = multi; act = a;
      @(negedge clk);
      ctl_we = 1'b0; act = A_NONE;
   endtask

   task automatic mask_wr(input logic [NH-1:0] m);
      @(negedge clk);
      mask_we = 1'b1; mask_wdata = m;
      @(negedge clk);
      mask_we = 1'b0;
   endtask

   task automatic set_hart(input logic [NH-1:0] h, input logic [NH-1:0] r);
      @(negedge clk);
      halted = h; running = r;
   endtask

   task automatic pulse_rdone(input logic [NH-1:0] p);
      @(negedge clk);
      rdone = p;
      @(negedge clk);
      rdone = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 index", 32'(sel_index_o), 32'h0);
      check("R1 enable/mask", 32'({multi_en_o, mask_o}), 32'h0);
      check("R1 halt/resume req", 32'({halt_req, resume_req}), 32'h0);
      check("R1 hor/reset", 32'({hor, hreset}), 32'h0);
      check("R1 resumeack/havereset", 32'({any_ra, any_hr}), 32'h0);

      // R10 R11: table of selections and hart states
      for (int i = 0; i < NVEC; i++) begin
         mask_wr(VEC[i][19:16]);
         halted = VEC[i][15:12];
         running = VEC[i][11:8];
         ctl({5'd0, VEC[i][23:21]}, VEC[i][20], A_NONE);
         check($sformatf("R10 R11 vector %0d", i),
               32'({any_h, all_h, any_r, all_r, any_u, all_u, any_n, all_n}),
               32'(VEC[i][7:0]));
      end
      set_hart('0, '0);
      mask_wr('0);

      // R3: index width discovery
      ctl(8'hFF, 1'b0, A_NONE);
      check("R3 all-ones index readback", 32'(sel_index_o), 32'h07);

      // R4: halt of running/unavailable hart, then drop once halted
      ctl(8'd1, 1'b0, A_HALT);
      check("R4 halt sets request", 32'(halt_req), 32'b0010);
      set_hart(4'b0010, 4'b0000);
      @(negedge clk);
      check("R4 request drops after halted", 32'(halt_req), 32'b0000);
      ctl(8'd1, 1'b0, A_HALT);
      check("R4 halted hart ignores halt", 32'(halt_req), 32'b0000);

      // R5 R6: resume handshake
      ctl(8'd1, 1'b0, A_RES);
      check("R5 resume request to halted hart", 32'(resume_req), 32'b0010);
      check("R6 ack cleared by resume", 32'(any_ra), 32'h0);
      set_hart(4'b0000, 4'b0010);
      @(negedge clk);
      check("R5 request drops when running", 32'(resume_req), 32'b0000);
      check("R6 ack set after running", 32'(any_ra), 32'h1);
      ctl(8'd1, 1'b0, A_RES);
      check("R5 running hart gets no request", 32'(resume_req), 32'b0000);
      check("R6 running hart ack stays clear", 32'(any_ra), 32'h0);

      // R5: halt wins over resume in the same write
      set_hart(4'b0100, 4'b0000);
      ctl(8'd2, 1'b0, A_HALT | A_RES);
      check("R5 halt+resume gives no resume", 32'({halt_req, resume_req}), 32'h00);

      // R2: mask selection with and without enable
      set_hart(4'b0000, 4'b0000);
      mask_wr(4'b0101);
      ctl(8'd1, 1'b1, A_HALT);
      check("R2 index plus mask selected", 32'(halt_req), 32'b0111);
      set_hart(4'b1111, 4'b0000);
      set_hart(4'b0000, 4'b0000);
      ctl(8'd3, 1'b0, A_HALT);
      check("R2 mask ignored with enable clear", 32'(halt_req), 32'b1000);
      set_hart(4'b1111, 4'b0000);
      set_hart(4'b0000, 4'b0000);

      // R12: toggling the enable leaves the mask alone
      ctl(8'd0, 1'b1, A_NONE);
      ctl(8'd0, 1'b0, A_NONE);
      check("R12 mask unchanged", 32'({multi_en_o, mask_o}), 32'b0_0101);

      // R7 R8: halt-on-reset and have-reset
      set_hart(4'b0000, 4'b0001);
      ctl(8'd0, 1'b0, A_SHOR);
      check("R7 hor set for selected", 32'(hor), 32'b0001);
      pulse_rdone(4'b0001);
      check("R7 reset exit raises halt request", 32'(halt_req), 32'b0001);
      check("R8 have-reset set", 32'(any_hr), 32'h1);
      ctl(8'd1, 1'b0, A_CHOR);
      check("R7 clear on other hart ignored", 32'(hor), 32'b0001);
      ctl(8'd0, 1'b0, A_CHOR);
      check("R7 clear on selected hart", 32'(hor), 32'b0000);

      pulse_rdone(4'b0100);
      ctl(8'd0, 1'b0, A_ACK);
      check("R8 ack clears selected", 32'(any_hr), 32'h0);
      ctl(8'd2, 1'b0, A_NONE);
      check("R8 unselected flag kept", 32'(any_hr), 32'h1);
      ctl(8'd0, 1'b1, A_NONE);
      check("R8 R11 any/all have-reset", 32'({any_hr, all_hr}), 32'b10);

      // R9: hart-reset level per selected hart
      mask_wr(4'b1010);
      ctl(8'd0, 1'b1, A_HRST);
      check("R9 reset to selected", 32'(hreset), 32'b1011);
      ctl(8'd3, 1'b0, A_NONE);
      check("R9 reset cleared for selected only", 32'(hreset), 32'b0011);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule